// File: doc/BRIEF.md
# Serial Port Register Front End

This block is the register front end of a serial port. A processor reaches it over a simple 32-bit word bus with four registers: a control word, a receive-data port, a transmit-data port and a status word. Behind it sit two FIFOs. The transmit FIFO holds bytes waiting for the frame engine. The receive FIFO holds characters that the frame engine has delivered. The block does not do the serial framing. It passes the control word to the frame engine, feeds that engine with transmit bytes through a valid/ready handshake, and accepts received characters together with an error flag.

Status events are held in sticky bits that software clears by writing 1. These events are receive data waiting, transmit space available, receive overrun, transmit overflow and receive character error. Two of these bits, masked by their enables, drive a level interrupt. The status word also shows the transmit fill level, the full and empty flags, the flow-control pins and a transmitter busy indication. When auto flow control is on, the block drives the request-to-send output from the free space in the receive FIFO, and it holds transmission back until clear-to-send is high.

Top module: `ser_csr_front`

## Requirements
- R1: After reset the control word reads 0 and the interrupt is low. The status word reads 0x422: receive-empty (bit 5), transmit-empty (bit 10) and transmit-space pending (bit 1) are set, and everything else is 0.
- R2: The control word (word index 0) stores all 32 bits written to it, reads them back, and drives them unchanged on `cfg_word`. Bit 15 is the global enable, bit 12 is auto flow, bit 18 is the receive interrupt enable and bit 19 is the transmit interrupt enable.
- R3: A write to word index 2 pushes bits 7:0 of the write data into the transmit FIFO (depth `TX_DEPTH`, 16 by default). Status bits 16:11 give the fill level. Bit 6 is set while the FIFO is full and bit 10 is set while it is empty. Bytes leave the FIFO in the order they were written.
- R4: A transmit write while the transmit FIFO is full is dropped, does not change the level, and sets status bit 3.
- R5: `tx_valid` is high only while the global enable is set, the transmit FIFO is not empty, and either auto flow is off or `cts_in` is high. One byte leaves the FIFO on each cycle where `tx_valid` and `tx_ready` are both high.
- R6: A read of word index 1 returns the oldest received character in bits 7:0, with the upper bits zero, and removes that character. A read while the receive FIFO is empty returns 0.
- R7: A character offered on `rx_valid` while the receive FIFO is full is dropped and sets status bit 2. Characters offered while the global enable is clear are ignored.
- R8: A character accepted with `rx_err` high is still stored, and it sets status bit 4.
- R9: Writing status (word index 3) clears each of bits 4:0 that has a 1 in the write data. Written values in bits 31:5 have no effect.
- R10: Status bit 0 is set on every cycle the receive FIFO holds data. Status bit 1 is set on every cycle the transmit level is below half the depth. In both cases the set condition wins over a clear write made in the same cycle.
- R11: `irq` is (bit 0 AND receive enable) OR (bit 1 AND transmit enable), and it is held low while the global enable is clear.
- R12: Status bit 7 shows `cts_in`. `rts_out` is high only while auto flow is on and the receive FIFO has at least two free entries. Status bit 8 shows `rts_out`.
- R13: Status bit 17 shows the `tx_busy` input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_word | input | 2 | Register word index |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational) |
| irq | output | 1 | Level interrupt |
| cfg_word | output | 32 | Control word to the frame engine |
| tx_data | output | 8 | Head byte of the transmit FIFO |
| tx_valid | output | 1 | Transmit byte offered |
| tx_ready | input | 1 | Frame engine takes the byte |
| tx_busy | input | 1 | Transmitter shifting |
| rx_data | input | 8 | Received character |
| rx_valid | input | 1 | Received character strobe |
| rx_err | input | 1 | Framing or parity error on this character |
| cts_in | input | 1 | Clear-to-send pin |
| rts_out | output | 1 | Request-to-send pin |

## Verification
The bench fills the transmit FIFO to exactly its depth and then writes once more. A design with an off-by-one on the full flag would either lose the last accepted byte or accept the extra one, and the drained byte order would show it. The bench moves the receive fill across 14 and 15 entries, where request-to-send must drop, and across full, where an overrun must be flagged and the character lost. It checks that a write-1 clear against an active set condition leaves the pending bit set, and that a read of an empty receive FIFO returns zero instead of stale data. It also blocks transmission with the enable cleared and with clear-to-send low, and checks that neither case consumes any bytes.

// File: rtl/ser_csr_pkg.sv
package ser_csr_pkg;

  // register word indices (address bits 3:2)
  localparam logic [1:0] WORD_CTRL = 2'd0;
  localparam logic [1:0] WORD_RXD  = 2'd1;
  localparam logic [1:0] WORD_TXD  = 2'd2;
  localparam logic [1:0] WORD_STAT = 2'd3;

  // control word fields
  localparam int CB_AUTOFLOW = 12;
  localparam int CB_ENABLE   = 15;
  localparam int CB_RX_IE    = 18;
  localparam int CB_TX_IE    = 19;

  // sticky status events, in status bit order
  localparam int NUM_EVT   = 5;
  localparam int EV_RXPEND = 0;
  localparam int EV_TXPEND = 1;
  localparam int EV_RXOVR  = 2;
  localparam int EV_TXOVF  = 3;
  localparam int EV_RXERR  = 4;

  // live status fields
  localparam int SB_RXEMPTY = 5;
  localparam int SB_TXFULL  = 6;
  localparam int SB_CTS     = 7;
  localparam int SB_RTS     = 8;
  localparam int SB_TXEMPTY = 10;
  localparam int SB_LVL_LO  = 11;
  localparam int LVL_W      = 6;
  localparam int SB_BUSY    = 17;

endpackage

// File: rtl/ser_fifo.sv
module ser_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     push,
  input  logic                     pop,
  input  logic [W-1:0]             din,
  output logic [W-1:0]             dout,
  output logic [$clog2(DEPTH):0]   cnt,
  output logic                     full,
  output logic                     empty
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  generate
    if ((1 << AW) != DEPTH) begin : g_bad_depth
      $error("ser_fifo depth must be a power of two");
    end
  endgenerate

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp_q, wp_d, rp_q, rp_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    wp_d  = push ? wp_q + 1'b1 : wp_q;
    rp_d  = pop  ? rp_q + 1'b1 : rp_q;
    cnt_d = cnt_q;
    if (push && !pop)      cnt_d = cnt_q + 1'b1;
    else if (pop && !push) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wp_q] <= din;
  end

  assign dout  = mem[rp_q];
  assign cnt   = cnt_q;
  assign full  = (cnt_q == CW'(DEPTH));
  assign empty = (cnt_q == '0);

  // R4
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> !push);
  // R6
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    empty |-> !pop);
  // R3
  level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH));

endmodule

// File: rtl/ser_irq_stat.sv
module ser_irq_stat #(
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  input  logic         glb_en,
  input  logic         rx_ie,
  input  logic         tx_ie,
  output logic [N-1:0] flags_o,
  output logic         irq_o
);
  import ser_csr_pkg::*;

  logic [N-1:0] flags_q, flags_d;
  logic         past_ok;

  // set dominates a same-cycle clear
  always_comb flags_d = (flags_q & ~clr_i) | set_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
      past_ok <= 1'b0;
    end else begin
      flags_q <= flags_d;
      past_ok <= 1'b1;
    end
  end

  assign flags_o = flags_q;
  assign irq_o   = glb_en & ((flags_q[EV_RXPEND] & rx_ie) |
                             (flags_q[EV_TXPEND] & tx_ie));

  // R11
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !glb_en |-> !irq_o);

  generate
    for (genvar i = 0; i < N; i++) begin : g_evt
      // R10
      set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(set_i[i])) |-> flags_q[i]);
      // R9
      w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(clr_i[i] && !set_i[i])) |-> !flags_q[i]);
    end
  endgenerate

endmodule

// File: rtl/ser_csr_front.sv
module ser_csr_front #(
  parameter int TX_DEPTH = 16,
  parameter int RX_DEPTH = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_sel,
  input  logic        bus_wr,
  input  logic [1:0]  bus_word,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        irq,
  output logic [31:0] cfg_word,
  output logic [7:0]  tx_data,
  output logic        tx_valid,
  input  logic        tx_ready,
  input  logic        tx_busy,
  input  logic [7:0]  rx_data,
  input  logic        rx_valid,
  input  logic        rx_err,
  input  logic        cts_in,
  output logic        rts_out
);
  import ser_csr_pkg::*;

  localparam int TXCW = $clog2(TX_DEPTH) + 1;
  localparam int RXCW = $clog2(RX_DEPTH) + 1;

  generate
    if (TX_DEPTH != 16 && TX_DEPTH != 32) begin : g_bad_tx
      $error("TX_DEPTH must be 16 or 32");
    end
  endgenerate

  // reset: asynchronous assert, synchronous release
  logic rst_meta, rst_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_s    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_s    <= rst_meta;
    end
  end

  // bus decode
  logic wr_ctrl, wr_txd, wr_stat, rd_rxd;
  assign wr_ctrl = bus_sel &  bus_wr & (bus_word == WORD_CTRL);
  assign wr_txd  = bus_sel &  bus_wr & (bus_word == WORD_TXD);
  assign wr_stat = bus_sel &  bus_wr & (bus_word == WORD_STAT);
  assign rd_rxd  = bus_sel & ~bus_wr & (bus_word == WORD_RXD);

  // control word
  logic [31:0] ctrl_q, ctrl_d;
  always_comb ctrl_d = wr_ctrl ? bus_wdata : ctrl_q;
  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) ctrl_q <= '0;
    else        ctrl_q <= ctrl_d;
  end

  logic glb_en, autoflow;
  assign glb_en   = ctrl_q[CB_ENABLE];
  assign autoflow = ctrl_q[CB_AUTOFLOW];
  assign cfg_word = ctrl_q;

  // transmit path
  logic            tx_push, tx_pop, tx_full, tx_empty;
  logic [TXCW-1:0] tx_cnt;
  assign tx_push  = wr_txd & ~tx_full;
  assign tx_valid = glb_en & ~tx_empty & (~autoflow | cts_in);
  assign tx_pop   = tx_valid & tx_ready;

  ser_fifo #(.W(8), .DEPTH(TX_DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_s), .push(tx_push), .pop(tx_pop),
    .din(bus_wdata[7:0]), .dout(tx_data), .cnt(tx_cnt),
    .full(tx_full), .empty(tx_empty)
  );

  // receive path
  logic            rx_acc, rx_push, rx_pop, rx_full, rx_empty;
  logic [RXCW-1:0] rx_cnt;
  logic [7:0]      rx_head;
  assign rx_acc  = glb_en & rx_valid;
  assign rx_push = rx_acc & ~rx_full;
  assign rx_pop  = rd_rxd & ~rx_empty;

  ser_fifo #(.W(8), .DEPTH(RX_DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_s), .push(rx_push), .pop(rx_pop),
    .din(rx_data), .dout(rx_head), .cnt(rx_cnt),
    .full(rx_full), .empty(rx_empty)
  );

  assign rts_out = autoflow & (rx_cnt <= RXCW'(RX_DEPTH - 2));

  // sticky events and interrupt
  logic [NUM_EVT-1:0] evt_set, evt_clr, evt_q;
  always_comb begin
    evt_set            = '0;
    evt_set[EV_RXPEND] = ~rx_empty;
    evt_set[EV_TXPEND] = tx_cnt < TXCW'(TX_DEPTH / 2);
    evt_set[EV_RXOVR]  = rx_acc & rx_full;
    evt_set[EV_TXOVF]  = wr_txd & tx_full;
    evt_set[EV_RXERR]  = rx_push & rx_err;
    evt_clr            = wr_stat ? bus_wdata[NUM_EVT-1:0] : '0;
  end

  ser_irq_stat #(.N(NUM_EVT)) u_evt (
    .clk(clk), .rst_n(rst_s), .set_i(evt_set), .clr_i(evt_clr),
    .glb_en(glb_en), .rx_ie(ctrl_q[CB_RX_IE]), .tx_ie(ctrl_q[CB_TX_IE]),
    .flags_o(evt_q), .irq_o(irq)
  );

  // status word
  logic [LVL_W-1:0] tx_lvl;
  logic [31:0]      stat_word;
  always_comb begin
    tx_lvl               = '0;
    tx_lvl[TXCW-1:0]     = tx_cnt;
    stat_word            = '0;
    stat_word[NUM_EVT-1:0] = evt_q;
    stat_word[SB_RXEMPTY]  = rx_empty;
    stat_word[SB_TXFULL]   = tx_full;
    stat_word[SB_CTS]      = cts_in;
    stat_word[SB_RTS]      = rts_out;
    stat_word[SB_TXEMPTY]  = tx_empty;
    stat_word[SB_LVL_LO +: LVL_W] = tx_lvl;
    stat_word[SB_BUSY]     = tx_busy;
  end

  always_comb begin
    unique case (bus_word)
      WORD_CTRL: bus_rdata = ctrl_q;
      WORD_RXD:  bus_rdata = rx_empty ? 32'd0 : {24'd0, rx_head};
      WORD_STAT: bus_rdata = stat_word;
      default:   bus_rdata = 32'd0;
    endcase
  end

  // R12
  rts_room_chk: assert property (@(posedge clk) disable iff (!rst_s)
    rts_out |-> !rx_full);
  // R4
  tx_drop_chk: assert property (@(posedge clk) disable iff (!rst_s)
    (wr_txd && tx_full && !tx_pop) |=> tx_cnt == $past(tx_cnt));
  // R7
  rx_ovr_chk: assert property (@(posedge clk) disable iff (!rst_s)
    (rx_valid && glb_en && rx_full) |=> evt_q[EV_RXOVR]);
  // R5
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_s)
    (autoflow && !cts_in) |-> !tx_pop);

endmodule

// File: tb/ser_csr_front_tb.sv
module ser_csr_front_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 0, bus_wr = 0;
  logic [1:0]  bus_word = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic        irq, tx_valid, rts_out;
  logic [31:0] cfg_word;
  logic [7:0]  tx_data, rx_data = 0;
  logic        tx_ready = 0, tx_busy = 0, rx_valid = 0, rx_err = 0, cts_in = 0;

  always #5 clk = ~clk;

  ser_csr_front u_dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_word(bus_word), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq(irq), .cfg_word(cfg_word), .tx_data(tx_data), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .tx_busy(tx_busy), .rx_data(rx_data),
    .rx_valid(rx_valid), .rx_err(rx_err), .cts_in(cts_in), .rts_out(rts_out)
  );

  localparam logic [31:0] EN = 32'h8000, AF = 32'h1000;
  localparam logic [31:0] RIE = 32'h4_0000, TIE = 32'h8_0000;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;
  logic [7:0] txq[$], rxq[$], got[$];

  always @(posedge clk) if (tx_valid && tx_ready) got.push_back(tx_data);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  function automatic logic [31:0] exp_stat(int txn, int rxn, bit cts, bit rts, bit busy);
    logic [31:0] s = '0;
    s[5] = (rxn == 0);
    s[6] = (txn == 16);
    s[7] = cts;
    s[8] = rts;
    s[10] = (txn == 0);
    s[16:11] = 6'(txn);
    s[17] = busy;
    return s;
  endfunction

  task automatic bw(logic [1:0] w, logic [31:0] d);
    @(negedge clk); bus_sel = 1; bus_wr = 1; bus_word = w; bus_wdata = d;
    @(negedge clk); bus_sel = 0; bus_wr = 0;
  endtask

  task automatic br(logic [1:0] w, output logic [31:0] d);
    @(negedge clk); bus_sel = 1; bus_wr = 0; bus_word = w;
    #1 d = bus_rdata;
    @(negedge clk); bus_sel = 0;
  endtask

  task automatic rxp(logic [7:0] b, bit e);
    @(negedge clk); rx_valid = 1; rx_data = b; rx_err = e;
    @(negedge clk); rx_valid = 0; rx_err = 0;
  endtask

  task automatic drain(int n);
    @(negedge clk); tx_ready = 1;
    repeat (n) @(negedge clk);
    tx_ready = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] s, s2, d;
    void'($urandom(32'd20240));
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R1 reset state
    br(0, d); chk("R1 ctrl", d, 0);
    chk("R1 irq", irq, 0);
    br(3, s); chk("R1 status", s, 32'h422);

    // R2 control word
    bw(0, 32'h00A5_0F73);
    br(0, d); chk("R2 readback", d, 32'h00A5_0F73);
    chk("R2 cfg_word", cfg_word, 32'h00A5_0F73);
    chk("R11 irq off when disabled", irq, 0);

    // R3 fill transmit FIFO, low byte only
    bw(0, EN);
    for (int i = 0; i < 16; i++) begin
      bw(2, 32'hABCD_0000 | (i * 7 + 3));
      txq.push_back(8'(i * 7 + 3));
      if (i == 7) begin
        br(3, s); chk("R3 level 8", s & ~32'h1F, exp_stat(8, 0, 0, 0, 0));
      end
    end
    br(3, s); chk("R3 full", s & ~32'h1F, exp_stat(16, 0, 0, 0, 0));
    // R4 overflow write
    bw(2, 32'h1FF);
    br(3, s); chk("R4 ovf bit", s[3], 1);
    chk("R4 level kept", s & ~32'h1F, exp_stat(16, 0, 0, 0, 0));
    // R9 upper bits of status write ignored
    bw(3, 32'hFFFF_FFE0);
    br(3, s2); chk("R9 no effect", s2, s);
    bw(3, 32'h8);
    br(3, s); chk("R9 w1c bit3", s[3], 0);
    // R10 tx pending clears while level at/above half
    bw(3, 32'h2);
    br(3, s); chk("R10 txpend cleared", s[1], 0);
    bw(0, EN | TIE);
    chk("R11 irq low", irq, 0);
    drain(9);
    br(3, s);
    chk("R10 txpend set", s[1], 1);
    chk("R3 level 7", s & ~32'h1F, exp_stat(7, 0, 0, 0, 0));
    chk("R11 irq high", irq, 1);
    // R5 disabled: no transfer
    bw(0, TIE);
    chk("R11 irq gated", irq, 0);
    drain(4);
    br(3, s); chk("R5 hold when disabled", s[16:11], 7);
    // R5 cts low with auto flow
    bw(0, EN | AF | TIE);
    drain(5);
    br(3, s); chk("R5 hold on cts", s[16:11], 7);
    cts_in = 1;
    drain(10);
    br(3, s); chk("R3 empty", s & ~32'h1F, exp_stat(0, 0, 1, 1, 0));
    chk("R5 count", got.size(), 16);
    for (int i = 0; i < 16 && i < got.size(); i++) chk("R3 order", got[i], txq[i]);
    txq.delete(); got.delete();

    // receive path with auto flow
    bw(0, EN | AF | RIE);
    for (int i = 0; i < 14; i++) begin rxp(8'(8'h40 + i), 0); rxq.push_back(8'(8'h40 + i)); end
    chk("R12 rts at 14", rts_out, 1);
    br(3, s); chk("R12 rts bit", s[8], 1);
    chk("R12 cts bit", s[7], 1);
    rxp(8'h4E, 0); rxq.push_back(8'h4E);
    chk("R12 rts drop at 15", rts_out, 0);
    rxp(8'h4F, 0); rxq.push_back(8'h4F);
    rxp(8'hEE, 0);
    br(3, s);
    chk("R7 overrun", s[2], 1);
    chk("R7 rx not empty", s[5], 0);
    chk("R10 rxpend", s[0], 1);
    chk("R11 rx irq", irq, 1);
    bw(3, 32'h1);
    br(3, s); chk("R10 set wins", s[0], 1);
    for (int i = 0; i < 16; i++) begin br(1, d); chk("R6 rx order", d, {24'd0, rxq[i]}); end
    rxq.delete();
    br(1, d); chk("R6 empty read", d, 0);
    bw(3, 32'h5);
    br(3, s); chk("R10 rxpend clear", s[0], 0);
    chk("R7 ovr clear", s[2], 0);
    chk("R11 irq idle", irq, 0);
    // R8 error char
    rxp(8'h99, 1);
    br(3, s); chk("R8 err bit", s[4], 1);
    br(1, d); chk("R8 char kept", d, 32'h99);
    bw(3, 32'h11);
    br(3, s); chk("R8 clear", s[4], 0);
    // R7 ignored while disabled
    bw(0, 0);
    rxp(8'h12, 0);
    br(3, s); chk("R7 ignored disabled", s[5], 1);
    br(1, d); chk("R7 no data", d, 0);
    // R13 busy
    tx_busy = 1; br(3, s); chk("R13 busy", s[17], 1);
    tx_busy = 0; br(3, s); chk("R13 idle", s[17], 0);

    // random mix, R3 R6 R7
    bw(0, EN);
    for (int it = 0; it < 300; it++) begin
      int op = int'($urandom % 4);
      logic [7:0] b = 8'($urandom);
      case (op)
        0: begin bw(2, {24'h0, b}); if (txq.size() < 16) txq.push_back(b); end
        1: begin rxp(b, 0); if (rxq.size() < 16) rxq.push_back(b); end
        2: begin
          br(1, d);
          if (rxq.size() > 0) chk("R6 random read", d, {24'd0, rxq.pop_front()});
          else chk("R6 random empty", d, 0);
        end
        default: begin
          br(3, s);
          chk("R3 random status", s & ~32'h1F, exp_stat(txq.size(), rxq.size(), 1, 0, 0));
        end
      endcase
    end
    drain(20);
    chk("R5 random count", got.size(), txq.size());
    for (int i = 0; i < txq.size() && i < got.size(); i++) chk("R3 random order", got[i], txq[i]);

    finish_run();
  end
endmodule